// File: doc/BRIEF.md
# Branch Condition and Target Unit

This unit resolves one decoded relative-branch instruction per accepted cycle. The decode stage presents the opcode byte, up to two displacement bytes, the address of the following sequential instruction, the six processor flags and an operand taken from the register file. One clock later the unit reports whether the branch is taken, the next program counter, how many execution states the instruction consumes and, for the decrement-and-branch forms, the decremented counter that must be written back.

Supported families are flag-conditional jumps, the short jump with an 11-bit offset split between opcode and second byte, the long jump with a 16-bit offset, jumps on a single bit of a byte operand, and decrement-and-branch on a byte or a word counter. Any other opcode is reported as illegal. All address arithmetic wraps modulo 2^16.

Top module: `br_resolve`

## Requirements
- R1: Conditional jumps use opcodes D0h..DFh with a sign-extended 8-bit displacement in `disp_lo_i`; flag bits are `flags_i[0]`=Z, `[1]`=N, `[2]`=C, `[3]`=V, `[4]`=VT, `[5]`=ST. DFh/D7h jump on Z set/clear, DBh/D3h on C, DDh/D5h on V, DCh/D4h on VT, D8h/D0h on ST.
- R2: D9h jumps when C=1 and Z=0, D1h when that is false; DEh jumps when N=1, D6h when N=0; D2h jumps when N=0 and Z=0, DAh when N=1 or Z=1.
- R3: A conditional jump reports 4 states when not taken and 8 when taken.
- R4: Opcodes 20h..27h are short jumps, always taken, 8 states; the offset is `{opcode[2:0], disp_lo_i}` sign-extended from 11 bits and added to `next_pc_i`.
- R5: Opcode E7h is a long jump, always taken, 8 states, offset `{disp_hi_i, disp_lo_i}` added to `next_pc_i`.
- R6: Opcodes 38h..3Fh jump when bit `opcode[2:0]` of `operand_i[7:0]` is 1, opcodes 30h..37h when it is 0; 5 states not taken, 9 taken; displacement as in R1.
- R7: Opcode E0h decrements `operand_i[7:0]`, reports `cnt_wr_o`=1 and `cnt_o`={00h, result}, and jumps when the result is nonzero; 5 states not taken, 9 taken.
- R8: Opcode E1h decrements the whole `operand_i`, reports it on `cnt_o` with `cnt_wr_o`=1, and jumps when the result is nonzero; 5 states not taken, 10 taken.
- R9: When not taken, `target_o` equals `next_pc_i`; every taken target wraps modulo 2^16.
- R10: Any other opcode sets `illegal_o`, with `taken_o`=0, `cnt_wr_o`=0, `states_o`=0 and `target_o`=`next_pc_i`.
- R11: Results appear one cycle after `in_valid_i` with `out_valid_o`=1; without a request, and after reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | A branch request is present |
| opcode_i | input | 8 | Opcode byte |
| disp_lo_i | input | 8 | Displacement byte (low part) |
| disp_hi_i | input | 8 | Displacement high byte (long jump) |
| next_pc_i | input | 16 | Address of the next sequential instruction |
| flags_i | input | 6 | Z, N, C, V, VT, ST at bits 0..5 |
| operand_i | input | 16 | Bit-test byte or decrement counter |
| out_valid_o | output | 1 | Result valid |
| taken_o | output | 1 | Branch taken |
| target_o | output | 16 | Next program counter |
| states_o | output | 4 | Execution state count |
| illegal_o | output | 1 | Unsupported opcode |
| cnt_wr_o | output | 1 | Decremented counter must be written back |
| cnt_o | output | 16 | Decremented counter value |

## Verification
A wrong condition decode or polarity shows as a flipped `taken_o` and a target equal to the fall-through address instead of the branch address, in the cycle right after the request. A mis-assembled or wrongly sign-extended offset shows as a target off by a power of two, most visibly for short-jump offsets with bit 10 set and for wrap across FFFFh. A wrong state table or decrement width appears as a mismatched `states_o` or `cnt_o` on the same result, so every fault is visible one cycle after the stimulus.

// File: rtl/br_resolve_pkg.sv
package br_resolve_pkg;

    localparam int unsigned BR_ADDR_W  = 16;
    localparam int unsigned BR_BYTE_W  = 8;
    localparam int unsigned BR_FLAG_N  = 6;
    localparam int unsigned BR_STATE_W = 4;

    // flag bit positions inside flags_i
    localparam int unsigned FL_Z  = 0;
    localparam int unsigned FL_N  = 1;
    localparam int unsigned FL_C  = 2;
    localparam int unsigned FL_V  = 3;
    localparam int unsigned FL_VT = 4;
    localparam int unsigned FL_ST = 5;

    typedef enum logic [2:0] {
        KIND_ILLEGAL,
        KIND_COND,
        KIND_SHORT,
        KIND_LONG,
        KIND_BITTEST,
        KIND_DEC_BYTE,
        KIND_DEC_WORD
    } br_kind_e;

    typedef struct packed {
        logic                  valid;
        logic                  taken;
        logic [BR_ADDR_W-1:0]  target;
        logic [BR_STATE_W-1:0] states;
        logic                  illegal;
        logic                  cnt_wr;
        logic [BR_ADDR_W-1:0]  cnt;
    } br_result_t;

endpackage

// File: rtl/br_decode.sv
module br_decode
    import br_resolve_pkg::*;
(
    input  logic [BR_BYTE_W-1:0]  opcode_i,
    output br_kind_e              kind_o,
    output logic [2:0]            low3_o,
    output logic                  pol_o,
    output logic [BR_STATE_W-1:0] st_taken_o,
    output logic [BR_STATE_W-1:0] st_fall_o
);
    always_comb begin
        kind_o     = KIND_ILLEGAL;
        low3_o     = opcode_i[2:0];
        pol_o      = opcode_i[3];
        st_taken_o = '0;
        st_fall_o  = '0;
        if (opcode_i[7:4] == 4'hD) begin
            kind_o     = KIND_COND;
            st_taken_o = 4'd8;
            st_fall_o  = 4'd4;
        end else if (opcode_i[7:3] == 5'b00100) begin
            kind_o     = KIND_SHORT;
            st_taken_o = 4'd8;
            st_fall_o  = 4'd8;
        end else if (opcode_i[7:4] == 4'h3) begin
            kind_o     = KIND_BITTEST;
            st_taken_o = 4'd9;
            st_fall_o  = 4'd5;
        end else if (opcode_i == 8'hE7) begin
            kind_o     = KIND_LONG;
            st_taken_o = 4'd8;
            st_fall_o  = 4'd8;
        end else if (opcode_i == 8'hE0) begin
            kind_o     = KIND_DEC_BYTE;
            st_taken_o = 4'd9;
            st_fall_o  = 4'd5;
        end else if (opcode_i == 8'hE1) begin
            kind_o     = KIND_DEC_WORD;
            st_taken_o = 4'd10;
            st_fall_o  = 4'd5;
        end
    end
endmodule

// File: rtl/br_cond_eval.sv
module br_cond_eval
    import br_resolve_pkg::*;
(
    input  logic [BR_FLAG_N-1:0] flags_i,
    input  logic [2:0]           sel_i,
    input  logic                 pol_i,
    output logic                 hit_o
);
    logic [7:0] base;

    // base[k] is the "true" sense of condition group k; pol selects sense
    always_comb begin
        base[0] = flags_i[FL_ST];
        base[1] = flags_i[FL_C] & ~flags_i[FL_Z];
        base[2] = flags_i[FL_N] | flags_i[FL_Z];
        base[3] = flags_i[FL_C];
        base[4] = flags_i[FL_VT];
        base[5] = flags_i[FL_V];
        base[6] = flags_i[FL_N];
        base[7] = flags_i[FL_Z];
        hit_o   = pol_i ? base[sel_i] : ~base[sel_i];
    end
endmodule

// File: rtl/br_target_calc.sv
module br_target_calc
    import br_resolve_pkg::*;
#(
    parameter int unsigned ADDR_W  = BR_ADDR_W,
    parameter int unsigned SHORT_W = 11
) (
    input  br_kind_e             kind_i,
    input  logic [2:0]           low3_i,
    input  logic [7:0]           disp_lo_i,
    input  logic [7:0]           disp_hi_i,
    input  logic [ADDR_W-1:0]    next_pc_i,
    output logic [ADDR_W-1:0]    target_o
);
    localparam int unsigned BYTE_EXT  = ADDR_W - 8;
    localparam int unsigned SHORT_EXT = ADDR_W - SHORT_W;

    logic [SHORT_W-1:0] short_off;
    logic [ADDR_W-1:0]  offset;

    always_comb begin
        short_off = {low3_i, disp_lo_i};
        unique case (kind_i)
            KIND_SHORT: offset = {{SHORT_EXT{short_off[SHORT_W-1]}}, short_off};
            KIND_LONG:  offset = {disp_hi_i, disp_lo_i};
            KIND_COND, KIND_BITTEST, KIND_DEC_BYTE, KIND_DEC_WORD:
                        offset = {{BYTE_EXT{disp_lo_i[7]}}, disp_lo_i};
            default:    offset = '0;
        endcase
        target_o = next_pc_i + offset;
    end
endmodule

// File: rtl/br_resolve.sv
module br_resolve
    import br_resolve_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid_i,
    input  logic [7:0]             opcode_i,
    input  logic [7:0]             disp_lo_i,
    input  logic [7:0]             disp_hi_i,
    input  logic [15:0]            next_pc_i,
    input  logic [5:0]             flags_i,
    input  logic [15:0]            operand_i,
    output logic                   out_valid_o,
    output logic                   taken_o,
    output logic [15:0]            target_o,
    output logic [3:0]             states_o,
    output logic                   illegal_o,
    output logic                   cnt_wr_o,
    output logic [15:0]            cnt_o
);
    br_kind_e              kind;
    logic [2:0]            low3;
    logic                  pol;
    logic [BR_STATE_W-1:0] st_taken, st_fall;
    logic                  cond_hit;
    logic [BR_ADDR_W-1:0]  br_target;
    logic [BR_BYTE_W-1:0]  dec_byte;
    logic [BR_ADDR_W-1:0]  dec_word;

    br_result_t res_d, res_q;

    br_decode u_decode (
        .opcode_i   (opcode_i),
        .kind_o     (kind),
        .low3_o     (low3),
        .pol_o      (pol),
        .st_taken_o (st_taken),
        .st_fall_o  (st_fall)
    );

    br_cond_eval u_cond (
        .flags_i (flags_i),
        .sel_i   (low3),
        .pol_i   (pol),
        .hit_o   (cond_hit)
    );

    br_target_calc #(.ADDR_W(BR_ADDR_W)) u_target (
        .kind_i    (kind),
        .low3_i    (low3),
        .disp_lo_i (disp_lo_i),
        .disp_hi_i (disp_hi_i),
        .next_pc_i (next_pc_i),
        .target_o  (br_target)
    );

    always_comb begin
        logic take;
        dec_byte = operand_i[7:0] - 8'd1;
        dec_word = operand_i - 16'd1;
        res_d    = '0;
        take     = 1'b0;
        if (in_valid_i) begin
            res_d.valid = 1'b1;
            unique case (kind)
                KIND_COND:     take = cond_hit;
                KIND_SHORT,
                KIND_LONG:     take = 1'b1;
                KIND_BITTEST:  take = (operand_i[low3] == pol);
                KIND_DEC_BYTE: begin
                    take         = (dec_byte != '0);
                    res_d.cnt_wr = 1'b1;
                    res_d.cnt    = {8'h00, dec_byte};
                end
                KIND_DEC_WORD: begin
                    take         = (dec_word != '0);
                    res_d.cnt_wr = 1'b1;
                    res_d.cnt    = dec_word;
                end
                default:       res_d.illegal = 1'b1;
            endcase
            res_d.taken  = take;
            res_d.target = take ? br_target : next_pc_i;
            res_d.states = take ? st_taken : st_fall;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid_o = res_q.valid;
    assign taken_o     = res_q.taken;
    assign target_o    = res_q.target;
    assign states_o    = res_q.states;
    assign illegal_o   = res_q.illegal;
    assign cnt_wr_o    = res_q.cnt_wr;
    assign cnt_o       = res_q.cnt;

    // R10
    illegal_never_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!taken_o && !cnt_wr_o && states_o == 4'd0));

    // R9
    fallthrough_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !taken_o) |-> (target_o == $past(next_pc_i)));

    // R3
    taken_state_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> (states_o >= 4'd8));

    // R7
    dec_zero_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr_o && !taken_o) |-> (cnt_o == 16'h0000 || $past(opcode_i) == 8'hE0 && cnt_o[7:0] == 8'h00));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid_i) |-> (!out_valid_o && !taken_o && !illegal_o && !cnt_wr_o));

    // R8
    word_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && opcode_i == 8'hE1) |=> (cnt_wr_o && cnt_o == $past(operand_i) - 16'd1));
endmodule

// File: tb/br_resolve_tb.sv
module br_resolve_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid_i;
    logic [7:0]  opcode_i, disp_lo_i, disp_hi_i;
    logic [15:0] next_pc_i, operand_i;
    logic [5:0]  flags_i;
    logic        out_valid_o, taken_o, illegal_o, cnt_wr_o;
    logic [15:0] target_o, cnt_o;
    logic [3:0]  states_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    br_resolve u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .opcode_i(opcode_i),
        .disp_lo_i(disp_lo_i), .disp_hi_i(disp_hi_i), .next_pc_i(next_pc_i),
        .flags_i(flags_i), .operand_i(operand_i), .out_valid_o(out_valid_o),
        .taken_o(taken_o), .target_o(target_o), .states_o(states_o),
        .illegal_o(illegal_o), .cnt_wr_o(cnt_wr_o), .cnt_o(cnt_o)
    );

    // expected result from the requirement text
    task automatic model(input logic [7:0] op, input logic [7:0] dl, input logic [7:0] dh,
                         input logic [15:0] pc, input logic [5:0] f, input logic [15:0] opd,
                         output logic t, output logic [15:0] tg, output logic [3:0] st,
                         output logic ill, output logic cw, output logic [15:0] cv,
                         output string req);
        logic z, n, c, v, vt, s;
        logic [15:0] off;
        logic [3:0] st_t, st_f;
        z = f[0]; n = f[1]; c = f[2]; v = f[3]; vt = f[4]; s = f[5];
        t = 1'b0; ill = 1'b0; cw = 1'b0; cv = 16'h0;
        off = {{8{dl[7]}}, dl};
        st_t = 4'd0; st_f = 4'd0;
        req = "R10";
        if (op >= 8'hD0 && op <= 8'hDF) begin
            st_t = 8; st_f = 4; req = "R1";
            case (op)
                8'hD0: t = !s;          8'hD8: t = s;
                8'hD3: t = !c;          8'hDB: t = c;
                8'hD4: t = !vt;         8'hDC: t = vt;
                8'hD5: t = !v;          8'hDD: t = v;
                8'hD7: t = !z;          8'hDF: t = z;
                8'hD1: begin t = !(c && !z); req = "R2"; end
                8'hD9: begin t = c && !z;    req = "R2"; end
                8'hD2: begin t = !n && !z;   req = "R2"; end
                8'hDA: begin t = n || z;     req = "R2"; end
                8'hD6: begin t = !n;         req = "R2"; end
                default: begin t = n;        req = "R2"; end
            endcase
        end else if (op >= 8'h20 && op <= 8'h27) begin
            t = 1; st_t = 8; st_f = 8; req = "R4";
            off = {{5{op[2]}}, op[2:0], dl};
        end else if (op == 8'hE7) begin
            t = 1; st_t = 8; st_f = 8; req = "R5";
            off = {dh, dl};
        end else if (op >= 8'h30 && op <= 8'h3F) begin
            st_t = 9; st_f = 5; req = "R6";
            t = op[3] ? opd[op[2:0]] : !opd[op[2:0]];
        end else if (op == 8'hE0) begin
            st_t = 9; st_f = 5; req = "R7"; cw = 1;
            cv = {8'h00, opd[7:0] - 8'd1};
            t = (cv != 0);
        end else if (op == 8'hE1) begin
            st_t = 10; st_f = 5; req = "R8"; cw = 1;
            cv = opd - 16'd1;
            t = (cv != 0);
        end else ill = 1'b1;
        tg = t ? pc + off : pc;
        st = t ? st_t : st_f;
    endtask

    task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // drive at negedge, result checked at the next negedge
    task automatic apply(input logic [7:0] op, input logic [7:0] dl, input logic [7:0] dh,
                         input logic [15:0] pc, input logic [5:0] f, input logic [15:0] opd);
        logic t, ill, cw;
        logic [15:0] tg, cv;
        logic [3:0] st;
        string req;
        in_valid_i = 1; opcode_i = op; disp_lo_i = dl; disp_hi_i = dh;
        next_pc_i = pc; flags_i = f; operand_i = opd;
        model(op, dl, dh, pc, f, opd, t, tg, st, ill, cw, cv, req);
        @(negedge clk);
        check("R11", "out_valid", {15'd0, out_valid_o}, 16'd1);
        check(req, "taken", {15'd0, taken_o}, {15'd0, t});
        check(t ? req : "R9", "target", target_o, tg);
        check(req, "states", {12'd0, states_o}, {12'd0, st});
        check("R10", "illegal", {15'd0, illegal_o}, {15'd0, ill});
        check(req, "cnt_wr", {15'd0, cnt_wr_o}, {15'd0, cw});
        check(req, "cnt", cnt_o, cv);
    endtask

    initial begin
        #1500000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = 32'd12345;
        void'($urandom(seed));
        rst_n = 0; in_valid_i = 0; opcode_i = 0; disp_lo_i = 0; disp_hi_i = 0;
        next_pc_i = 0; flags_i = 0; operand_i = 0;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11", "reset valid", {15'd0, out_valid_o}, 16'd0);
        check("R11", "reset target", target_o, 16'd0);
        rst_n = 1;
        @(negedge clk);
        // R11 idle cycle
        check("R11", "idle taken", {15'd0, taken_o}, 16'd0);

        // R4 short jump to itself and to next instruction
        apply(8'h27, 8'hFE, 8'h00, 16'h8222, 6'h00, 16'h0);
        check("R4", "self loop", target_o, 16'h8220);
        apply(8'h20, 8'h00, 8'h00, 16'h832A, 6'h3F, 16'h0);
        check("R4", "zero offset", target_o, 16'h832A);
        apply(8'h24, 8'h00, 8'h00, 16'h1000, 6'h00, 16'h0);
        check("R4", "most negative", target_o, 16'h0C00);
        // R5 long jump with wrap (R9)
        apply(8'hE7, 8'h20, 8'h00, 16'hFFF0, 6'h00, 16'h0);
        check("R9", "wrap", target_o, 16'h0010);
        apply(8'hE7, 8'h9D, 8'h02, 16'h800F, 6'h00, 16'h0);
        check("R5", "long", target_o, 16'h82AC);
        // R7 byte decrement corners
        apply(8'hE0, 8'hFC, 8'h00, 16'h4000, 6'h00, 16'hAB01);
        check("R7", "byte to zero falls", {15'd0, taken_o}, 16'd0);
        apply(8'hE0, 8'hFC, 8'h00, 16'h4000, 6'h00, 16'h1200);
        check("R7", "byte wraps", cnt_o, 16'h00FF);
        // R8 word decrement corners
        apply(8'hE1, 8'hF0, 8'h00, 16'h4000, 6'h00, 16'h0000);
        check("R8", "word wraps", cnt_o, 16'hFFFF);
        apply(8'hE1, 8'hF0, 8'h00, 16'h4000, 6'h00, 16'h0100);
        check("R8", "word high byte", {15'd0, taken_o}, 16'd1);
        // R6 bit tests
        apply(8'h3F, 8'h10, 8'h00, 16'h2000, 6'h00, 16'h0080);
        apply(8'h30, 8'h10, 8'h00, 16'h2000, 6'h00, 16'h00FE);
        // R10 illegal opcodes
        apply(8'hFF, 8'h10, 8'h10, 16'h1234, 6'h3F, 16'h0001);
        apply(8'h00, 8'h10, 8'h10, 16'h5678, 6'h3F, 16'h0001);
        // R1 R2 every conditional under every flag combination
        for (int o = 8'hD0; o <= 8'hDF; o++)
            for (int f = 0; f < 64; f++)
                apply(o[7:0], 8'h80, 8'h00, 16'h0040, f[5:0], 16'h0);

        for (int i = 0; i < 3000; i++) begin
            logic [7:0] op;
            logic [15:0] opd;
            int k;
            k = $urandom_range(0, 7);
            case (k)
                0: op = 8'hD0 | 8'($urandom_range(0, 15));
                1: op = 8'h20 | 8'($urandom_range(0, 7));
                2: op = 8'h30 | 8'($urandom_range(0, 15));
                3: op = 8'hE0 | 8'($urandom_range(0, 1));
                4: op = 8'hE7;
                default: op = 8'($urandom);
            endcase
            opd = 16'($urandom);
            if ($urandom_range(0, 3) == 0) opd = 16'($urandom_range(0, 2));
            apply(op, 8'($urandom), 8'($urandom), 16'($urandom), 6'($urandom), opd);
            if ($urandom_range(0, 7) == 0) begin
                in_valid_i = 0;
                @(negedge clk);
                check("R11", "gap valid", {15'd0, out_valid_o}, 16'd0);
                check("R11", "gap cnt_wr", {15'd0, cnt_wr_o}, 16'd0);
            end
        end
        in_valid_i = 0;
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule